// File: doc/BRIEF.md
# Four-Task Issue Slot Scheduler with Exclusive Lock

This unit picks which of four hardware tasks supplies the next fetch of a pipelined core. In its normal state it walks a sixteen-entry table of task IDs, one entry per issue slot, wrapping from the last entry to the first. A table-load event replaces the whole sequence in one cycle and also sets or clears a multitask-mode flag. Other logic uses that flag to decide whether wait-type instructions loop on themselves or stall the pipeline.

A lock event gives one task the whole pipeline. From the next issue slot on, only that task is fetched, and the table position stays frozen. A free event does not end the lock at once, because two instructions of the locked task are already in flight. Exactly two more issue slots go to the locked task, and only then does the table walk resume from the frozen position. A table load that arrives during this release window is held back and applied at the moment the walk resumes. A task jump aimed at the locked task cancels the lock at once.

Issue slots are the cycles with `adv` high. A stalled cycle issues nothing, so it moves neither the table position nor the release countdown.

Top module: `task_slot_sched`

## Requirements
- R1: After reset, every table entry holds task 0, no lock is active and `multi_mode` is 0. `issue_task` is 0 for the first 16 issue slots.
- R2: Each cycle with `adv`=1 issues the table entry at the current position and then moves the position to the next entry. The position wraps from entry 15 to entry 0. Entry i is bits [2i+1:2i] of `load_slots`.
- R3: A load with no lock active replaces the table from the next cycle on. The position is unchanged by a load. A cycle with `adv`=0 leaves the position unchanged, so `issue_task` holds.
- R4: A `lock_req` accepted while no lock is active makes `issue_task` equal `lock_id` in every cycle from the next one on, until the lock ends. The slot of the lock cycle itself still comes from the table.
- R5: A `lock_req` while a lock is active, including during the release window, is ignored. The locked task does not change.
- R6: After a `free_req` cycle of an active lock, exactly two more issue slots give the locked task. The next issue slot comes from the table.
- R7: When the table walk resumes, it starts at the entry after the one issued in the lock cycle.
- R8: Cycles with `adv`=0 during the release window do not count toward the two release slots.
- R9: A load during the release window leaves the table and `multi_mode` unchanged until the lock ends. The load then takes effect for the first table slot after release.
- R10: A `jump_req` whose `jump_id` equals the locked task ends the lock. The next cycle issues from the table. A jump to any other task has no effect.
- R11: `multi_mode` takes the value of `load_multi` on the same cycle that the table is written by that load.
- R12: A `free_req` while no lock is active is ignored, and the table walk continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv | input | 1 | Issue slot happens this cycle (low = pipeline stall) |
| lock_req | input | 1 | Lock event |
| lock_id | input | 2 | Task that issued the lock |
| free_req | input | 1 | Free event |
| load_req | input | 1 | Table-load event |
| load_slots | input | 32 | New table, entry i in bits [2i+1:2i] |
| load_multi | input | 1 | Multitask-mode value stored with the table |
| jump_req | input | 1 | Task-jump event |
| jump_id | input | 2 | Task targeted by the jump |
| issue_task | output | 2 | Task ID for the current fetch slot |
| multi_mode | output | 1 | Multitask-mode flag |

## Verification
A table load can arrive inside the release window, where it has to be deferred and then applied exactly when the last release slot ends the lock. The bench sends the load in the first slot after the free event. It then checks that `multi_mode` keeps its old value through the second release slot. The first slot after release must show the new table's entry at the frozen position, and the new flag value. A stall inside the window and a jump that cancels the lock are also sent in the cycles around the countdown. The bench judges each one by the exact slot in which `issue_task` goes back to the table.

// File: rtl/tss_pkg.sv
package tss_pkg;

  // advance a ring index of n positions
  function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // true when a release countdown at cnt ends on this slot
  function automatic logic release_done(int unsigned cnt);
    return cnt == 1;
  endfunction

endpackage

// File: rtl/tss_lock_ctrl.sv
module tss_lock_ctrl #(
  parameter int TASKS     = 4,
  parameter int REL_DEPTH = 2,
  localparam int TW = $clog2(TASKS),
  localparam int CW = $clog2(REL_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          lock_req,
  input  logic [TW-1:0] lock_id,
  input  logic          free_req,
  input  logic          jump_req,
  input  logic [TW-1:0] jump_id,
  output logic          locked,
  output logic [TW-1:0] owner,
  output logic          releasing,
  output logic          lock_end,
  output logic          cancel
);
  import tss_pkg::*;

  logic [CW-1:0] cnt;
  logic          take;
  logic          free_ok;
  logic          rel_last;

  assign take     = lock_req && !locked;
  assign cancel   = locked && jump_req && (jump_id == owner);
  assign free_ok  = locked && !releasing && free_req && !cancel;
  assign rel_last = locked && releasing && adv && release_done(32'(cnt));
  assign lock_end = cancel || rel_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      owner     <= '0;
      releasing <= 1'b0;
      cnt       <= '0;
    end else if (lock_end) begin
      locked    <= 1'b0;
      releasing <= 1'b0;
      cnt       <= '0;
    end else if (take) begin
      locked <= 1'b1;
      owner  <= lock_id;
    end else if (free_ok) begin
      releasing <= 1'b1;
      cnt       <= CW'(REL_DEPTH);
    end else if (releasing && adv) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R5
  relock_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && lock_req && !lock_end) |=> ($stable(owner) && locked));

  // R8
  stall_freezes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (releasing && !adv && !cancel) |=> ($stable(cnt) && releasing));

  // R10
  jump_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !locked);

  // R12
  free_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && free_req && !lock_req) |=> !releasing);

endmodule

// File: rtl/tss_slot_table.sv
module tss_slot_table #(
  parameter int TASKS = 4,
  parameter int SLOTS = 16,
  localparam int TW = $clog2(TASKS),
  localparam int PW = $clog2(SLOTS),
  localparam int DW = TW * SLOTS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          hold,
  input  logic          defer,
  input  logic          lock_end,
  input  logic          load_req,
  input  logic [DW-1:0] load_slots,
  input  logic          load_multi,
  output logic [TW-1:0] cur_task,
  output logic          multi_mode
);
  import tss_pkg::*;

  logic [DW-1:0] table_q;
  logic [DW-1:0] pend_slots;
  logic          pend_multi;
  logic          pend_vld;
  logic [PW-1:0] ptr;
  logic [TW-1:0] slot_view [SLOTS];

  logic          wr_now;
  logic          wr_end;
  logic          wr_en;
  logic          park;
  logic [DW-1:0] wr_data;
  logic          wr_multi;

  genvar gi;
  generate
    for (gi = 0; gi < SLOTS; gi++) begin : g_view
      assign slot_view[gi] = table_q[gi*TW +: TW];
    end
  endgenerate

  assign cur_task = slot_view[ptr];

  assign wr_now   = load_req && !defer;
  assign wr_end   = lock_end && (pend_vld || load_req);
  assign wr_en    = wr_now || wr_end;
  assign park     = load_req && defer && !lock_end;
  assign wr_data  = load_req ? load_slots : pend_slots;
  assign wr_multi = load_req ? load_multi : pend_multi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      table_q    <= '0;
      multi_mode <= 1'b0;
    end else if (wr_en) begin
      table_q    <= wr_data;
      multi_mode <= wr_multi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_slots <= '0;
      pend_multi <= 1'b0;
      pend_vld   <= 1'b0;
    end else if (park) begin
      pend_slots <= load_slots;
      pend_multi <= load_multi;
      pend_vld   <= 1'b1;
    end else if (lock_end) begin
      pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (adv && !hold) begin
      ptr <= PW'(ring_next(32'(ptr), SLOTS));
    end
  end

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv || hold) |=> $stable(ptr));

  // R9
  deferred_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> ($stable(table_q) && $stable(multi_mode)));

  // R11
  flag_with_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !defer) |=> (multi_mode == $past(load_multi)));

endmodule

// File: rtl/task_slot_sched.sv
module task_slot_sched #(
  parameter int TASKS     = 4,
  parameter int SLOTS     = 16,
  parameter int REL_DEPTH = 2,
  localparam int TW = $clog2(TASKS),
  localparam int DW = TW * SLOTS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          lock_req,
  input  logic [TW-1:0] lock_id,
  input  logic          free_req,
  input  logic          load_req,
  input  logic [DW-1:0] load_slots,
  input  logic          load_multi,
  input  logic          jump_req,
  input  logic [TW-1:0] jump_id,
  output logic [TW-1:0] issue_task,
  output logic          multi_mode
);

  logic          locked;
  logic [TW-1:0] owner;
  logic          releasing;
  logic          lock_end;
  logic          cancel;
  logic [TW-1:0] cur_task;

  tss_lock_ctrl #(.TASKS(TASKS), .REL_DEPTH(REL_DEPTH)) i_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .lock_req  (lock_req),
    .lock_id   (lock_id),
    .free_req  (free_req),
    .jump_req  (jump_req),
    .jump_id   (jump_id),
    .locked    (locked),
    .owner     (owner),
    .releasing (releasing),
    .lock_end  (lock_end),
    .cancel    (cancel)
  );

  tss_slot_table #(.TASKS(TASKS), .SLOTS(SLOTS)) i_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .hold       (locked),
    .defer      (releasing),
    .lock_end   (lock_end),
    .load_req   (load_req),
    .load_slots (load_slots),
    .load_multi (load_multi),
    .cur_task   (cur_task),
    .multi_mode (multi_mode)
  );

  assign issue_task = locked ? owner : cur_task;

  // R4
  lock_takes_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_req && !locked) |=> (issue_task == $past(lock_id)));

  // R6
  release_holds_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (releasing && !lock_end) |=> (issue_task == $past(owner)));

endmodule

// File: tb/test_task_slot_sched.sv
module test_task_slot_sched;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 1'b0;
  logic        lock_req = 1'b0;
  logic [1:0]  lock_id = '0;
  logic        free_req = 1'b0;
  logic        load_req = 1'b0;
  logic [31:0] load_slots = '0;
  logic        load_multi = 1'b0;
  logic        jump_req = 1'b0;
  logic [1:0]  jump_id = '0;
  logic [1:0]  issue_task;
  logic        multi_mode;

  int tests = 0;
  int fails = 0;
  int p = 0;
  logic [1:0] cur_tbl [16];

  always #2 clk = ~clk;

  task_slot_sched i_task_slot_sched (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .lock_req(lock_req), .lock_id(lock_id), .free_req(free_req),
    .load_req(load_req), .load_slots(load_slots), .load_multi(load_multi),
    .jump_req(jump_req), .jump_id(jump_id),
    .issue_task(issue_task), .multi_mode(multi_mode)
  );

  function automatic logic [1:0] ent_a(int i);
    return 2'((i * 3 + 1) % 4);
  endfunction

  function automatic logic [1:0] ent_b(int i);
    return 2'((i >> 1) % 4);
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: check issue_task, then let the edge happen
  task automatic tick(logic a, int exp, string tag);
    adv = a;
    check(tag, issue_task, exp);
    @(negedge clk);
    lock_req = 0; free_req = 0; load_req = 0; jump_req = 0;
  endtask

  // one table slot, model position moves on
  task automatic tslot(string tag);
    tick(1'b1, cur_tbl[p], tag);
    p = (p + 1) % 16;
  endtask

  task automatic t_reset();
    check("R1 flag", multi_mode, 0);
    for (int i = 0; i < 16; i++) tslot("R1 slot");
  endtask

  task automatic t_load_walk();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) v[2*i +: 2] = ent_a(i);
    load_slots = v; load_multi = 1; load_req = 1;
    tick(1'b0, cur_tbl[p], "R3 load cycle old");
    for (int i = 0; i < 16; i++) cur_tbl[i] = ent_a(i);
    check("R11 flag set", multi_mode, 1);
    for (int i = 0; i < 17; i++) tslot("R2 walk");
  endtask

  task automatic t_stall();
    for (int i = 0; i < 3; i++) tick(1'b0, cur_tbl[p], "R3 stall");
    tslot("R3 after stall");
  endtask

  task automatic t_lock_free();
    lock_req = 1; lock_id = 2;
    tslot("R4 lock cycle");
    for (int i = 0; i < 5; i++) begin
      if (i == 2) begin lock_req = 1; lock_id = 1; end
      tick(1'b1, 2, (i > 2) ? "R5 relock" : "R4 locked");
    end
    free_req = 1;
    tick(1'b1, 2, "R6 free cycle");
    lock_req = 1; lock_id = 0;
    tick(1'b1, 2, "R6 release 1");
    tick(1'b1, 2, "R6 release 2");
    tslot("R7 resume");
    tslot("R7 resume next");
  endtask

  task automatic t_stall_release();
    lock_req = 1; lock_id = 3;
    tslot("R8 lock cycle");
    free_req = 1;
    tick(1'b1, 3, "R8 free cycle");
    tick(1'b0, 3, "R8 stall 1");
    tick(1'b0, 3, "R8 stall 2");
    tick(1'b1, 3, "R8 release 1");
    tick(1'b1, 3, "R8 release 2");
    tslot("R8 resume");
  endtask

  task automatic t_deferred_load();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) v[2*i +: 2] = ent_b(i);
    lock_req = 1; lock_id = 1;
    tslot("R9 lock cycle");
    free_req = 1;
    tick(1'b1, 1, "R9 free cycle");
    load_slots = v; load_multi = 0; load_req = 1;
    tick(1'b1, 1, "R9 release 1");
    check("R9 flag held", multi_mode, 1);
    tick(1'b1, 1, "R9 release 2");
    for (int i = 0; i < 16; i++) cur_tbl[i] = ent_b(i);
    check("R11 flag cleared", multi_mode, 0);
    tslot("R9 new table");
    tslot("R9 new table next");
  endtask

  task automatic t_jump();
    lock_req = 1; lock_id = 2;
    tslot("R10 lock cycle");
    jump_req = 1; jump_id = 1;
    tick(1'b1, 2, "R10 other jump");
    tick(1'b1, 2, "R10 still locked");
    jump_req = 1; jump_id = 2;
    tick(1'b1, 2, "R10 jump cycle");
    tslot("R10 cancelled");
    tslot("R10 walk");
  endtask

  task automatic t_free_idle();
    free_req = 1;
    tslot("R12 free idle");
    for (int i = 0; i < 4; i++) tslot("R12 walk");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) cur_tbl[i] = 2'd0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    t_reset();
    t_load_walk();
    t_stall();
    t_lock_free();
    t_stall_release();
    t_deferred_load();
    t_jump();
    t_free_idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #40000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule